// File: doc/BRIEF.md
# Dual Read/Write Bank Mapper

This block sits between the host address path and the video memory controller. It turns a host address that falls inside a fixed 64 KB aperture into a wider video memory address by adding a bank number. Reads and writes each have their own bank number, so a host copy loop can read from one bank and write to another without reprogramming anything between the two accesses.

Three byte-wide registers set the mapping, and they are written through a small select/data port. The segment register holds the low bank bits. The extended register holds the high bank bits. The control register picks the register layout and can force linear mode. In wide layout each bank number is 6 bits, split across the segment and extended registers. In legacy layout each bank number is 3 bits and the top two bits of the segment register choose the segment configuration: 128 KB segments, 64 KB segments, or linear. In linear mode a contiguous 1 MB host window starting at the 1 MB boundary maps directly onto video memory.

Each access presented with `acc_valid_i` produces a registered result one clock later. The result is a hit flag and the translated address.

Top module: `bank_mapper`

## Requirements
- R1: After reset all three registers are zero (wide layout, banks 0, linear off), and `hit_o` and `mem_addr_o` are 0.
- R2: In wide layout with linear off, a host address in 0xA0000–0xAFFFF translates to bank × 0x10000 + address[15:0]. The write bank is {ext[1:0], seg[3:0]} and the read bank is {ext[5:4], seg[7:4]}. The bank used is chosen by `acc_write_i` (1 = write).
- R3: Extended register bits 2, 3, 6 and 7 have no effect on any translation.
- R4: In legacy layout (control bit 0 = 1) the write bank is seg[2:0] and the read bank is seg[5:3]. The extended register has no effect in this layout.
- R5: In legacy layout, segment configuration seg[7:6] = 1 and the reserved value 3 both select 64 KB banking, with the same window and formula as R2.
- R6: In legacy layout, seg[7:6] = 0 selects 128 KB segments. Host addresses 0xA0000–0xBFFFF hit, and the result is bank × 0x20000 + address[16:0].
- R7: Linear mode is selected by control bit 1 = 1, or by legacy layout with seg[7:6] = 2. In this mode host addresses 0x100000–0x1FFFFF hit and translate to address − 0x100000.
- R8: A cycle with `acc_valid_i` low, or with an address outside the active window, gives `hit_o` = 0 and `mem_addr_o` = 0.
- R9: The result of an access appears on the outputs after the next rising clock edge. A register write takes effect for accesses presented in the following cycle. An access in the same cycle as the write still uses the old value.
- R10: Register writes use `reg_sel_i` codes 0 = segment, 1 = extended, 2 = control. Code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 segment, 1 extended, 2 control) |
| reg_wdata_i | input | 8 | Register write data |
| acc_valid_i | input | 1 | Host access present this cycle |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_addr_i | input | 24 | Host byte address |
| hit_o | output | 1 | Registered: access decoded into the active window |
| mem_addr_o | output | 22 | Registered translated video memory address |

## Verification
The assertions assume that `reg_sel_i`, `reg_wdata_i` and the access inputs are settled at each rising edge. They also assume the aperture base keeps its 128 KB alignment, so the 128 KB and 64 KB windows share a base. The bench drives every input on the falling edge only. It keeps the aperture base at its default, and it also aims random addresses at the window edges and at the space between the windows. This exercises misses as well as hits under every layout.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_SEG  = 2'd0,
    SEL_EXT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // legacy segment configuration codes; order is decoded behaviour
  typedef enum logic [1:0] {
    SEGCFG_128K = 2'd0,
    SEGCFG_64K  = 2'd1,
    SEGCFG_LIN  = 2'd2,
    SEGCFG_RSV  = 2'd3
  } seg_cfg_e;

  typedef enum logic [1:0] {
    MAP_BANK64  = 2'd0,
    MAP_BANK128 = 2'd1,
    MAP_LINEAR  = 2'd2
  } map_mode_e;

  typedef struct packed {
    logic [REG_W-1:0] seg;
    logic [1:0]       ext_wr;
    logic [1:0]       ext_rd;
    logic             legacy;
    logic             lin_en;
  } bank_cfg_t;
endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import bank_map_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output bank_cfg_t        cfg_o
);
  bank_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (reg_sel_e'(sel_i))
        SEL_SEG:  cfg_q.seg <= wdata_i;
        SEL_EXT: begin
          cfg_q.ext_wr <= wdata_i[1:0];
          cfg_q.ext_rd <= wdata_i[5:4];
        end
        SEL_CTRL: begin
          cfg_q.legacy <= wdata_i[0];
          cfg_q.lin_en <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  p_sel3_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd3) |=> $stable(cfg_o));
endmodule

// File: rtl/bank_select.sv
module bank_select
  import bank_map_pkg::*;
#(
  parameter int BANK_W     = 6,
  parameter int LEG_BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_cfg_t         cfg_i,
  input  logic              is_write_i,
  output map_mode_e         mode_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam int NIB_W = REG_W / 2;

  logic [BANK_W-1:0] wide_wr, wide_rd, leg_wr, leg_rd;
  seg_cfg_e          seg_cfg;

  assign wide_wr = BANK_W'({cfg_i.ext_wr, cfg_i.seg[NIB_W-1:0]});
  assign wide_rd = BANK_W'({cfg_i.ext_rd, cfg_i.seg[REG_W-1:NIB_W]});
  assign leg_wr  = BANK_W'(cfg_i.seg[LEG_BANK_W-1:0]);
  assign leg_rd  = BANK_W'(cfg_i.seg[2*LEG_BANK_W-1:LEG_BANK_W]);
  assign seg_cfg = seg_cfg_e'(cfg_i.seg[REG_W-1:REG_W-2]);

  always_comb begin
    if (cfg_i.lin_en || (cfg_i.legacy && seg_cfg == SEGCFG_LIN))
      mode_o = MAP_LINEAR;
    else if (cfg_i.legacy && seg_cfg == SEGCFG_128K)
      mode_o = MAP_BANK128;
    else
      mode_o = MAP_BANK64;  // 64K and reserved code
  end

  always_comb begin
    if (cfg_i.legacy) bank_o = is_write_i ? leg_wr : leg_rd;
    else              bank_o = is_write_i ? wide_wr : wide_rd;
  end

  p_legacy_bank_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.legacy |-> (bank_o >> LEG_BANK_W) == '0);
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import bank_map_pkg::*;
#(
  parameter int          HOST_AW   = 24,
  parameter int          MEM_AW    = 22,
  parameter int          BANK_W    = 6,
  parameter logic [23:0] APER_BASE = 24'h0A0000,
  parameter logic [23:0] LIN_BASE  = 24'h100000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [HOST_AW-1:0] haddr_i,
  input  map_mode_e          mode_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic               hit_o,
  output logic [MEM_AW-1:0]  addr_o
);
  localparam int OFF64_W  = 16;
  localparam int OFF128_W = 17;
  localparam int LIN_W    = 20;
  localparam logic [HOST_AW-1:0] APER = HOST_AW'(APER_BASE);
  localparam logic [HOST_AW-1:0] LINB = HOST_AW'(LIN_BASE);
  localparam logic [HOST_AW-1:0] LINE = LINB + HOST_AW'(1 << LIN_W);

  logic              in64, in128, inlin;
  logic [MEM_AW-1:0] bank_ext, a64, a128, alin;
  logic [HOST_AW-1:0] lin_off;

  assign in64  = haddr_i[HOST_AW-1:OFF64_W]  == APER[HOST_AW-1:OFF64_W];
  assign in128 = haddr_i[HOST_AW-1:OFF128_W] == APER[HOST_AW-1:OFF128_W];
  assign inlin = (haddr_i >= LINB) && (haddr_i < LINE);

  assign bank_ext = MEM_AW'(bank_i);
  assign lin_off  = haddr_i - LINB;
  assign a64  = (bank_ext << OFF64_W)  | MEM_AW'(haddr_i[OFF64_W-1:0]);
  assign a128 = (bank_ext << OFF128_W) | MEM_AW'(haddr_i[OFF128_W-1:0]);
  assign alin = MEM_AW'(lin_off[LIN_W-1:0]);

  always_comb begin
    hit_o  = 1'b0;
    addr_o = '0;
    if (valid_i) begin
      unique case (mode_i)
        MAP_LINEAR:  begin hit_o = inlin; addr_o = inlin ? alin : '0; end
        MAP_BANK128: begin hit_o = in128; addr_o = in128 ? a128 : '0; end
        default:     begin hit_o = in64;  addr_o = in64  ? a64  : '0; end
      endcase
    end
  end

  p_linear_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_LINEAR && hit_o) |-> (addr_o >> LIN_W) == '0);
  p_bank64_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MAP_BANK64 && hit_o) |-> addr_o[OFF64_W-1:0] == haddr_i[OFF64_W-1:0]);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter int          HOST_AW    = 24,
  parameter int          MEM_AW     = 22,
  parameter int          BANK_W     = 6,
  parameter int          LEG_BANK_W = 3,
  parameter logic [23:0] APER_BASE  = 24'h0A0000,
  parameter logic [23:0] LIN_BASE   = 24'h100000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [7:0]         reg_wdata_i,
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic [HOST_AW-1:0] acc_addr_i,
  output logic               hit_o,
  output logic [MEM_AW-1:0]  mem_addr_o
);
  bank_cfg_t         cfg;
  map_mode_e         mode;
  logic [BANK_W-1:0] bank;
  logic              hit_d;
  logic [MEM_AW-1:0] addr_d;

  bank_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg)
  );

  bank_select #(.BANK_W(BANK_W), .LEG_BANK_W(LEG_BANK_W)) u_sel (
    .clk_i, .rst_ni,
    .cfg_i(cfg), .is_write_i(acc_write_i),
    .mode_o(mode), .bank_o(bank)
  );

  addr_xlate #(
    .HOST_AW(HOST_AW), .MEM_AW(MEM_AW), .BANK_W(BANK_W),
    .APER_BASE(APER_BASE), .LIN_BASE(LIN_BASE)
  ) u_xlate (
    .clk_i, .rst_ni,
    .valid_i(acc_valid_i), .haddr_i(acc_addr_i),
    .mode_i(mode), .bank_i(bank),
    .hit_o(hit_d), .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      mem_addr_o <= '0;
    end else begin
      hit_o      <= hit_d;
      mem_addr_o <= addr_d;
    end
  end

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> mem_addr_o == '0);
  p_idle_no_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!acc_valid_i) |-> !hit_o);
endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [23:0] acc_addr_i = '0;
  logic        hit_o;
  logic [21:0] mem_addr_o;

  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference state
  int m_seg = 0, m_ext = 0, m_ctrl = 0;
  bit exp_hit = 1'b0;
  int exp_addr = 0;

  always #2.5 clk_i = ~clk_i;

  bank_mapper dut (.*);

  function automatic void ref_xlate(input int a, input bit wr, output bit h, output int o);
    bit legacy = m_ctrl[0];
    int cfg    = (m_seg >> 6) & 3;
    int bank;
    h = 0; o = 0;
    if (m_ctrl[1] || (legacy && cfg == 2)) begin
      if (a >= 'h100000 && a < 'h200000) begin h = 1; o = a - 'h100000; end
    end else if (legacy && cfg == 0) begin
      bank = wr ? (m_seg & 7) : ((m_seg >> 3) & 7);
      if (a >= 'hA0000 && a < 'hC0000) begin h = 1; o = bank * 131072 + (a - 'hA0000); end
    end else begin
      if (legacy) bank = wr ? (m_seg & 7) : ((m_seg >> 3) & 7);
      else if (wr) bank = ((m_ext & 3) << 4) | (m_seg & 15);
      else bank = (((m_ext >> 4) & 3) << 4) | ((m_seg >> 4) & 15);
      if (a >= 'hA0000 && a < 'hB0000) begin h = 1; o = bank * 65536 + (a - 'hA0000); end
    end
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_seg = 0; m_ext = 0; m_ctrl = 0; exp_hit = 0; exp_addr = 0;
    end else begin
      bit h; int o;
      ref_xlate(int'(acc_addr_i), acc_write_i, h, o);
      exp_hit  = acc_valid_i && h;
      exp_addr = exp_hit ? o : 0;
      if (reg_we_i) begin
        case (reg_sel_i)
          2'd0: m_seg  = int'(reg_wdata_i);
          2'd1: m_ext  = int'(reg_wdata_i);
          2'd2: m_ctrl = int'(reg_wdata_i) & 3;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_vec++;
      if (hit_o !== exp_hit || int'(mem_addr_o) !== exp_addr) begin
        n_bad++;
        $display("FAIL %s: hit=%0b addr=%h expected hit=%0b addr=%h",
                 cur_req, hit_o, mem_addr_o, exp_hit, exp_addr[21:0]);
      end
    end
  end

  task automatic cyc(input bit we, input logic [1:0] sel, input logic [7:0] d,
                     input bit v, input bit w, input logic [23:0] a);
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = d;
    acc_valid_i = v; acc_write_i = w; acc_addr_i = a;
    @(negedge clk_i);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    cyc(1, sel, d, 0, 0, '0);
  endtask

  task automatic acc(input bit w, input logic [23:0] a);
    cyc(0, 2'd0, 8'h00, 1, w, a);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs held low in reset
    n_vec++;
    if (hit_o !== 1'b0 || mem_addr_o !== '0) begin
      n_bad++;
      $display("FAIL R1: hit=%0b addr=%h expected hit=0 addr=0", hit_o, mem_addr_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    cur_req = "R1"; acc(0, 24'h0A1234); acc(1, 24'h0AFFFF);

    cur_req = "R2";
    wr_reg(2'd0, 8'h53); wr_reg(2'd1, 8'h21);
    acc(0, 24'h0A1234); acc(1, 24'h0A1234); acc(0, 24'h0AFFFF); acc(1, 24'h0A0000);
    wr_reg(2'd0, 8'hFF); wr_reg(2'd1, 8'h33);
    acc(0, 24'h0A8001); acc(1, 24'h0A8001);

    cur_req = "R3";
    wr_reg(2'd1, 8'hCE); acc(0, 24'h0A0042); acc(1, 24'h0A0042);

    cur_req = "R9";
    cyc(1, 2'd0, 8'h71, 1, 1, 24'h0A0010);
    acc(1, 24'h0A0010); acc(0, 24'h0A0010);
    cyc(0, 2'd0, 8'h00, 0, 0, 24'h0A0010);

    cur_req = "R4";
    wr_reg(2'd2, 8'h01); wr_reg(2'd0, 8'h6A); wr_reg(2'd1, 8'h33);
    acc(0, 24'h0A2000); acc(1, 24'h0A2000);

    cur_req = "R5";
    wr_reg(2'd0, 8'hEB); acc(0, 24'h0AF00F); acc(1, 24'h0AF00F); acc(0, 24'h0B0000);

    cur_req = "R6";
    wr_reg(2'd0, 8'h33); acc(0, 24'h0B0010); acc(1, 24'h0A0010);
    acc(0, 24'h0BFFFF); acc(1, 24'h0C0000); acc(0, 24'h09FFFF);

    cur_req = "R7";
    wr_reg(2'd0, 8'h80); acc(0, 24'h1ABCDE); acc(1, 24'h100000);
    acc(0, 24'h200000); acc(0, 24'h0A0000); acc(1, 24'h0FFFFF);
    wr_reg(2'd2, 8'h02); wr_reg(2'd0, 8'h00); acc(0, 24'h1FFFFF); acc(1, 24'h0A0000);

    cur_req = "R8";
    wr_reg(2'd2, 8'h00);
    cyc(0, 2'd0, 8'h00, 0, 0, 24'h0A0005); acc(0, 24'h09FFFF); acc(1, 24'h0B0000);
    acc(0, 24'hFA0000);

    cur_req = "R10";
    wr_reg(2'd0, 8'h12); wr_reg(2'd3, 8'hFF); acc(0, 24'h0A0001); acc(1, 24'h0A0001);

    cur_req = "R2/random";
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] a;
      int r = $urandom_range(0, 5);
      case (r)
        0: a = 24'h0A0000 | 24'($urandom_range(0, 'hFFFF));
        1: a = 24'h0B0000 | 24'($urandom_range(0, 'hFFFF));
        2: a = 24'h100000 | 24'($urandom_range(0, 'hFFFFF));
        3: a = 24'h09FFFF + 24'($urandom_range(0, 2));
        4: a = 24'h1FFFFE + 24'($urandom_range(0, 3));
        default: a = 24'($urandom);
      endcase
      cyc($urandom_range(0, 3) == 0, 2'($urandom), 8'($urandom),
          $urandom_range(0, 4) != 0, 1'($urandom), a);
    end
    cyc(0, 2'd0, 8'h00, 0, 0, '0);
    finish_run();
  end
endmodule